// File: doc/BRIEF.md
# Control Line Glitch Monitor

This block watches a group of asynchronous bus control lines: request, grant, busy, acknowledge, interrupt, master-sync and slave-sync. It flags any excursion, high or low, that is shorter than a minimum legal width. Such pulses mean a line was glitched or driven wrongly. The monitor runs all the time on a sampling clock, so it can catch short pulses while the system is running. The clock must be fast enough to resolve a pulse of about 100 ns.

Each line has its own two-stage synchronizer and its own level tracker. The tracker counts how many cycles the synchronized level holds between two transitions. When a transition ends a run that is shorter than `MIN_WIDTH` cycles, that run is a violation. High and low runs are judged the same way and independently of each other. `MIN_WIDTH` is derived from the legal width in nanoseconds (275 by default) and the clock period. For each line the block reports three things:
- a sticky error flag,
- a saturating violation counter,
- the width of the most recent violation.

The tracker in each line has three states:
- `ST_ARM`: no transition has been seen since reset.
- `ST_HIGH`: the synchronized line is high and a run is being timed.
- `ST_LOW`: the synchronized line is low and a run is being timed.

The state machine has these transitions:
- `ARM_TO_HIGH`, `ARM_TO_LOW`: the first transition after reset. It only starts timing.
- `HIGH_TO_LOW`, `LOW_TO_HIGH`: a later transition. It ends the timed run, which is judged against the limit.
- All other cycles hold the current state.

Top module: `glitch_monitor`

## Requirements
- R1: Each line passes through two synchronizer flops before it is judged. A violation shows on the outputs on the third rising clock edge after the input change that ends the short pulse, and not earlier.
- R2: After reset, the first transition of a line only starts timing. It never counts as a violation, whatever its distance from reset.
- R3: The width of a run is the number of cycles that the synchronized level holds between two successive transitions. A run shorter than `MIN_WIDTH` is a violation. This applies to high runs and low runs alike, and a single-cycle pulse has width 1.
- R4: A run of exactly `MIN_WIDTH` cycles, or longer, is legal and changes none of the outputs.
- R5: Line i's sticky flag is bit i of `sticky_err`. A violation sets it, and it stays set until `clear` is asserted.
- R6: Line i's counter sits at bits `[i*CNT_W +: CNT_W]` of `viol_count`. Each violation adds one, and the counter stops at 2^CNT_W-1 without wrapping.
- R7: Line i's last violation width sits at bits `[i*WW +: WW]` of `last_width`, where WW = clog2(MIN_WIDTH+1). It is loaded with the width of each violation. Legal runs and `clear` leave it unchanged.
- R8: A cycle with `clear` high and no violation resets every sticky flag and every counter to zero.
- R9: Lines are independent. Activity on one line never changes another line's outputs.
- R10: After reset, all sticky flags, counters and widths read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Clears sticky flags and counters |
| lines_in | input | NUM_LINES | Asynchronous control lines under watch |
| sticky_err | output | NUM_LINES | Per-line sticky violation flag |
| viol_count | output | NUM_LINES*CNT_W | Per-line saturating violation counters, packed |
| last_width | output | NUM_LINES*WW | Per-line width of the latest violation, packed |

## Verification
The hardest cases to reach are at the edges of the limit: a run exactly `MIN_WIDTH` cycles long next to one that is a single cycle shorter, and a counter pushed into saturation. Both need transitions placed to the exact cycle. The bench drives every toggle on a falling edge and counts the hold in whole cycles, so a directed run can land on 27, 28 or 1 cycles exactly. Random steps draw their holds mostly from around the limit and from very short values, so that both sides of the boundary and repeated saturation occur often.

// File: rtl/glitch_pkg.sv
package glitch_pkg;
    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } run_state_t;
endpackage

// File: rtl/glitch_sync.sv
// Two-flop synchronizer plus a third stage used to detect a level change.
module glitch_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic toggled
);
    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign level   = stab_q;
    assign toggled = stab_q ^ prev_q;
endmodule

// File: rtl/line_checker.sv
// Per-line run tracker: times each level run and judges it at its closing edge.
module line_checker
    import glitch_pkg::*;
#(
    parameter int MIN_WIDTH = 28,
    parameter int CNT_W     = 8,
    localparam int WW       = $clog2(MIN_WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             level,
    input  logic             toggled,
    output logic             sticky,
    output logic [CNT_W-1:0] count,
    output logic [WW-1:0]    last_w
);
    localparam logic [WW-1:0]    MIN_W   = WW'(MIN_WIDTH);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_t       state_q, state_d;
    logic [WW-1:0]    run_q;
    logic             short_run;
    logic             sticky_q;
    logic [CNT_W-1:0] count_q;
    logic [WW-1:0]    last_w_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARM;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:  if (toggled) state_d = level ? ST_HIGH : ST_LOW; // ARM_TO_HIGH / ARM_TO_LOW
            ST_HIGH: if (toggled) state_d = ST_LOW;                   // HIGH_TO_LOW
            ST_LOW:  if (toggled) state_d = ST_HIGH;                  // LOW_TO_HIGH
            default: state_d = ST_ARM;
        endcase
    end

    // Run timer: 1 on the edge cycle, counts up to the limit and holds there
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                run_q <= '0;
        else if (toggled)                          run_q <= WW'(1);
        else if (state_q != ST_ARM && run_q < MIN_W) run_q <= run_q + WW'(1);
    end

    assign short_run = toggled && (state_q != ST_ARM) && (run_q < MIN_W);

    // Output process; a violation in the same cycle as clear takes priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
            count_q  <= '0;
            last_w_q <= '0;
        end else if (short_run) begin
            sticky_q <= 1'b1;
            last_w_q <= run_q;
            if (clear)                count_q <= CNT_W'(1);
            else if (count_q != CNT_MAX) count_q <= count_q + CNT_W'(1);
        end else if (clear) begin
            sticky_q <= 1'b0;
            count_q  <= '0;
        end
    end

    assign sticky = sticky_q;
    assign count  = count_q;
    assign last_w = last_w_q;

    AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> $stable(count_q) && !sticky_q); // R2
    AST_VIOL_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q) |-> (last_w_q != '0 && last_w_q < MIN_W)); // R3
    AST_LEGAL_RUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (toggled && state_q != ST_ARM && run_q >= MIN_W) |=> $stable(last_w_q)); // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !clear) |=> sticky_q); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !clear) |=> count_q == CNT_MAX); // R6
    AST_CLEAR_KEEPS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !short_run) |=> $stable(last_w_q) && count_q == '0); // R7
endmodule

// File: rtl/glitch_monitor.sv
module glitch_monitor #(
    parameter int NUM_LINES = 7,
    parameter int CLK_NS    = 10,
    parameter int LEGAL_NS  = 275,
    parameter int MIN_WIDTH = (LEGAL_NS + CLK_NS - 1) / CLK_NS,
    parameter int CNT_W     = 8,
    localparam int WW       = $clog2(MIN_WIDTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [NUM_LINES-1:0]       lines_in,
    output logic [NUM_LINES-1:0]       sticky_err,
    output logic [NUM_LINES*CNT_W-1:0] viol_count,
    output logic [NUM_LINES*WW-1:0]    last_width
);
    logic [NUM_LINES-1:0] lvl, tog;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        glitch_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (lines_in[i]),
            .level   (lvl[i]),
            .toggled (tog[i])
        );
        line_checker #(
            .MIN_WIDTH (MIN_WIDTH),
            .CNT_W     (CNT_W)
        ) u_chk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .level   (lvl[i]),
            .toggled (tog[i]),
            .sticky  (sticky_err[i]),
            .count   (viol_count[i*CNT_W +: CNT_W]),
            .last_w  (last_width[i*WW +: WW])
        );
    end
endmodule

// File: tb/glitch_monitor_test.sv
module glitch_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL    = 7;
    localparam int MINW  = 28;
    localparam int CW    = 3;
    localparam int WW    = $clog2(MINW + 1);
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic [NL-1:0] lines = '0;
    logic [NL-1:0] sticky_err;
    logic [NL*CW-1:0] viol_count;
    logic [NL*WW-1:0] last_width;

    int tests = 0, fails = 0;
    bit done = 0;
    int since[NL];
    bit armed[NL];
    bit exp_st[NL];
    int exp_cnt[NL];
    int exp_w[NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    glitch_monitor #(.NUM_LINES(NL), .MIN_WIDTH(MINW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .lines_in(lines),
        .sticky_err(sticky_err), .viol_count(viol_count), .last_width(last_width)
    );

    function automatic int next_cnt(int c);
        return (c >= CMAX) ? CMAX : c + 1;
    endfunction

    function automatic bit is_short(bit arm, int w);
        return arm && (w < MINW);
    endfunction

    task automatic tick();
        @(negedge clk);
        for (int i = 0; i < NL; i++) if (since[i] < 1000) since[i]++;
    endtask

    task automatic toggle(logic [NL-1:0] m);
        lines = lines ^ m;
        for (int i = 0; i < NL; i++) begin
            if (m[i]) begin
                if (is_short(armed[i], since[i])) begin
                    exp_st[i]  = 1'b1;
                    exp_cnt[i] = next_cnt(exp_cnt[i]);
                    exp_w[i]   = since[i];
                end
                armed[i] = 1'b1;
                since[i] = 0;
            end
        end
    endtask

    task automatic step(logic [NL-1:0] m, int k);
        toggle(m);
        repeat (k) tick();
    endtask

    task automatic check_all(string tag);
        repeat (5) tick();
        for (int i = 0; i < NL; i++) begin
            tests++;
            if (sticky_err[i] !== exp_st[i] ||
                int'(viol_count[i*CW +: CW]) != exp_cnt[i] ||
                int'(last_width[i*WW +: WW]) != exp_w[i]) begin
                fails++;
                $display("FAIL %s line %0d: got sticky=%0b cnt=%0d w=%0d exp sticky=%0b cnt=%0d w=%0d",
                         tag, i, sticky_err[i], viol_count[i*CW +: CW], last_width[i*WW +: WW],
                         exp_st[i], exp_cnt[i], exp_w[i]);
            end
        end
    endtask

    task automatic do_clear();
        repeat (5) tick();
        clear = 1'b1;
        tick();
        clear = 1'b0;
        for (int i = 0; i < NL; i++) begin
            exp_st[i] = 1'b0;
            exp_cnt[i] = 0;
        end
        tick();
    endtask

    task automatic single(string tag, bit got, bit exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b exp %0b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < NL; i++) begin
            since[i] = 0; armed[i] = 0; exp_st[i] = 0; exp_cnt[i] = 0; exp_w[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10 reset state");

        // R2: first edge right after reset; then R4 exact limit, R3 one short
        step(7'h01, 28);
        step(7'h01, 27);
        step(7'h01, 40);
        check_all("R2 R3 R4 limit boundary");

        // R3: low glitch on line 1, high glitch on line 2 just after arming
        step(7'h02, 40);
        step(7'h02, 1);
        step(7'h02, 40);
        step(7'h04, 1);
        step(7'h04, 40);
        check_all("R3 both polarities");

        // R1: latency of exactly three rising edges
        step(7'h10, 40);
        step(7'h10, 2);
        toggle(7'h10);
        tick(); tick();
        single("R1 not before third edge", sticky_err[4], 1'b0);
        tick();
        single("R1 on third edge", sticky_err[4], 1'b1);
        check_all("R1 settled");

        // R6 saturation on line 3; R9 others untouched
        for (int j = 0; j < 12; j++) step(7'h08, 2);
        step(7'h08, 40);
        check_all("R6 R9 saturation");

        // R7: legal runs leave widths alone; R5 sticky persists
        for (int j = 0; j < 4; j++) step(7'h01, 30 + j);
        repeat (60) tick();
        check_all("R5 R7 legal runs hold");

        // R8 clear; R7 width kept
        do_clear();
        check_all("R7 R8 after clear");

        // Random mix
        for (int s = 0; s < 260; s++) begin
            logic [NL-1:0] m;
            int k;
            m = NL'($urandom);
            case ($urandom % 4)
                0: k = 1 + int'($urandom % 4);
                1: k = 26 + int'($urandom % 5);
                2: k = 30 + int'($urandom % 20);
                default: k = 1 + int'($urandom % 40);
            endcase
            step(m, k);
            if (s % 13 == 12) check_all("R3 R6 R9 random");
            if (s % 61 == 60) begin
                do_clear();
                check_all("R8 random clear");
            end
        end
        check_all("R3 R5 final");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule